// File: doc/BRIEF.md
# Two-Lane Serial ID Transmitter with Echo Verification

This block is the master side of a slow identification download. After a start strobe it latches a 28-bit ID and announces the transfer with a long sync pulse. It then produces a slow, symmetric transfer clock and shifts the ID out over two data lanes in parallel, so the whole number goes out in 14 bit slots. The receiver returns each bit pair it sampled on two feedback lines. The block compares every returned pair with the pair it sent one slot earlier and records any difference in a sticky error flag.

All timing counts pulses of a 1 ms timebase tick that the surrounding chip supplies. The sync length and the transfer-clock half period are parameters given in ticks. The feedback lines pass through a two-flop synchroniser before they are compared. A transfer ends with a one-cycle done pulse, with the transfer clock left low.

Top module: `id_tx_echo`

## Requirements
- R1: A start strobe while idle raises sync_o on the next edge, and sync_o stays high for exactly SYNC_TICKS ticks (default 100).
- R2: sclk_o stays low for HALF_TICKS ticks after sync_o falls. It then runs 14 periods, each HALF_TICKS ticks high followed by HALF_TICKS ticks low (defaults give a 100 ms, 50 % clock). It stays low after the last period.
- R3: Lane data_o[0] carries ID bits 27 down to 14 and lane data_o[1] carries bits 13 down to 0, most significant first. Slot j therefore presents data_o = {id[13-j], id[27-j]}, and slot 0 appears on the start edge.
- R4: The data lanes change only on falling edges of sclk_o and on the start edge. They are stable across every rising edge and while sclk_o is high.
- R5: At rising edge k of sclk_o (k from 1 to 13), the synchronised feedback pair is compared with the pair of slot k-1. The pair of slot 13 is compared one full period after the last rising edge.
- R6: Any failed comparison sets mismatch_o. The flag stays set until the next accepted start, which clears it.
- R7: On the final comparison, done_o pulses high for one cycle and busy_o falls on the same edge. From the start edge until then, busy_o is high.
- R8: A start strobe while busy_o is high is ignored: the ID, the timing and the outputs are unaffected.
- R9: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| id_i | input | ID_W | Identification number to send |
| tick_i | input | 1 | One-cycle pulse per millisecond |
| fb_i | input | LINES | Echo lines from the receiver |
| sync_o | output | 1 | Transfer announcement pulse |
| sclk_o | output | 1 | Generated transfer clock |
| data_o | output | LINES | Data lanes, bit 0 is the upper half |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| mismatch_o | output | 1 | Sticky echo error flag |

## Verification
Every output is registered. A change caused by a tick, or by an accepted start, is therefore due in the system cycle right after the rising edge that sampled it. The bench model advances on that same edge, and the bench compares the model with the outputs on the following falling edge. The feedback lines reach the comparator two cycles late through the synchroniser, so the model keeps a two-deep history of fb_i and judges each echo against the value seen two edges before the comparing edge. The error cases place a corrupted echo in a middle slot and in the last slot. The last-slot case only shows up on the delayed final comparison.

// File: rtl/id_tx_pkg.sv
package id_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SYNC,
    ST_LOW,
    ST_HIGH
  } tx_state_e;
endpackage

// File: rtl/id_tx_sync.sv
module id_tx_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/id_tx_tick_timer.sv
module id_tx_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = tick_i && !clear_i && (cnt_q == limit_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clear_i || expire_o)  cnt_q <= '0;
    else if (tick_i)               cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/id_tx_lane.sv
module id_tx_lane #(
  parameter int SEG_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic             shift_i,
  output logic             bit_o
);
  logic [SEG_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= seg_i;
    else if (shift_i) sr_q <= {sr_q[SEG_W-2:0], 1'b0};
  end

  assign bit_o = sr_q[SEG_W-1];
endmodule

// File: rtl/id_tx_echo.sv
module id_tx_echo
  import id_tx_pkg::*;
#(
  parameter int ID_W       = 28,
  parameter int LINES      = 2,
  parameter int SYNC_TICKS = 100,
  parameter int HALF_TICKS = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic             tick_i,
  input  logic [LINES-1:0] fb_i,
  output logic             sync_o,
  output logic             sclk_o,
  output logic [LINES-1:0] data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             mismatch_o
);
  localparam int SEG_W  = ID_W / LINES;
  localparam int SLOTS  = SEG_W;
  localparam int MAXT   = (SYNC_TICKS > HALF_TICKS) ? SYNC_TICKS : HALF_TICKS;
  localparam int CNT_W  = $clog2(MAXT + 1);
  localparam int SLOT_W = $clog2(SLOTS + 1);

  tx_state_e         state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [LINES-1:0]  ref_q;
  logic [LINES-1:0]  fb_s;
  logic [CNT_W-1:0]  limit;
  logic              expire, load, shift;

  assign load  = (state_q == ST_IDLE) && start_i;
  assign shift = (state_q == ST_HIGH) && expire && (slot_q < SLOT_W'(SLOTS - 1));
  assign limit = (state_q == ST_SYNC) ? CNT_W'(SYNC_TICKS) : CNT_W'(HALF_TICKS);

  id_tx_sync #(.W(LINES)) u_fb_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (fb_i),
    .q_o   (fb_s)
  );

  id_tx_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (state_q == ST_IDLE),
    .tick_i  (tick_i),
    .limit_i (limit),
    .expire_o(expire)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_lane
    id_tx_lane #(.SEG_W(SEG_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .seg_i  (id_i[ID_W-1-l*SEG_W -: SEG_W]),
      .shift_i(shift),
      .bit_o  (data_o[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      slot_q     <= '0;
      ref_q      <= '0;
      sync_o     <= 1'b0;
      sclk_o     <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      mismatch_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q    <= ST_SYNC;
          sync_o     <= 1'b1;
          busy_o     <= 1'b1;
          mismatch_o <= 1'b0;
          slot_q     <= '0;
        end
        ST_SYNC: if (expire) begin
          sync_o  <= 1'b0;
          state_q <= ST_LOW;
        end
        // rise event: compare echo of previous slot, then raise clock or finish
        ST_LOW: if (expire) begin
          if (slot_q != '0 && fb_s != ref_q) mismatch_o <= 1'b1;
          ref_q <= data_o;
          if (slot_q == SLOT_W'(SLOTS)) begin
            state_q <= ST_IDLE;
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
          end else begin
            sclk_o  <= 1'b1;
            state_q <= ST_HIGH;
          end
        end
        ST_HIGH: if (expire) begin
          sclk_o  <= 1'b0;
          slot_q  <= slot_q + SLOT_W'(1);
          state_q <= ST_LOW;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/id_tx_echo_chk.sv
module id_tx_echo_chk #(
  parameter int LINES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             sync_o,
  input logic             sclk_o,
  input logic [LINES-1:0] data_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             mismatch_o
);
  assert_sync_in_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> (busy_o && !sclk_o));

  assert_sync_rise_from_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> !$past(busy_o));

  assert_data_hold_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(data_o));

  assert_data_hold_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(data_o));

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !sclk_o && !sync_o));

  assert_clk_in_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> busy_o);

  assert_mis_set_in_xfer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mismatch_o) |-> (busy_o || done_o));

  assert_mis_clear_on_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mismatch_o) |-> ($past(start_i) && !$past(busy_o)));
endmodule

bind id_tx_echo id_tx_echo_chk #(.LINES(LINES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .sync_o    (sync_o),
  .sclk_o    (sclk_o),
  .data_o    (data_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .mismatch_o(mismatch_o)
);

// File: tb/id_tx_echo_tb_top.sv
module id_tx_echo_tb_top;
  localparam int S = 100;
  localparam int H = 50;
  localparam int SLOTS = 14;
  localparam int T0 = S + H;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [27:0] id_i = '0;
  logic        tick_i = 1'b0;
  logic [1:0]  fb_i = '0;
  logic        sync_o, sclk_o, busy_o, done_o, mismatch_o;
  logic [1:0]  data_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  id_tx_echo dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .id_i(id_i),
    .tick_i(tick_i), .fb_i(fb_i), .sync_o(sync_o), .sclk_o(sclk_o),
    .data_o(data_o), .busy_o(busy_o), .done_o(done_o), .mismatch_o(mismatch_o)
  );

  // R3 pairing: data[0] = id[27-j], data[1] = id[13-j]
  function automatic logic [1:0] mpair(logic [27:0] id, int j);
    return {id[13-j], id[27-j]};
  endfunction

  // reference model
  logic        m_busy, m_done, m_mis, m_sync, m_sclk;
  logic [1:0]  m_data, fb_d1, fb_d2;
  logic [27:0] m_id;
  int t, k, idx;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_mis = 0; m_sync = 0; m_sclk = 0;
      m_data = '0; fb_d1 = '0; fb_d2 = '0; m_id = '0; t = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start_i) begin
          m_busy = 1; t = 0; m_id = id_i; m_mis = 0;
        end
      end else if (tick_i) begin
        t++;
        if (t >= T0 && ((t - T0) % (2*H)) == 0) begin
          k = (t - T0) / (2*H);
          if (k >= 1 && fb_d2 != mpair(m_id, k-1)) m_mis = 1;
          if (k == SLOTS) begin m_busy = 0; m_done = 1; end
        end
      end
      fb_d2 = fb_d1;
      fb_d1 = fb_i;
      if (m_busy) begin
        m_sync = (t < S);
        m_sclk = (t >= T0) && (((t - T0) % (2*H)) < H);
        if (t < T0 + H) idx = 0;
        else idx = (t - T0 - H) / (2*H) + 1;
        if (idx > SLOTS-1) idx = SLOTS-1;
        m_data = mpair(m_id, idx);
      end else begin
        m_sync = 0; m_sclk = 0;
      end
    end
  end

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // per-cycle comparison on the falling edge
  initial forever begin
    @(negedge clk_i);
    if (rst_ni && !finished) begin
      check("R1 sync_o", {1'b0, sync_o}, {1'b0, m_sync});
      check("R2 sclk_o", {1'b0, sclk_o}, {1'b0, m_sclk});
      check("R3 R4 data_o", data_o, m_data);
      check("R6 R5 mismatch_o", {1'b0, mismatch_o}, {1'b0, m_mis});
      check("R7 done_o", {1'b0, done_o}, {1'b0, m_done});
      check("R7 R8 busy_o", {1'b0, busy_o}, {1'b0, m_busy});
    end
  end

  // timebase: one tick every other cycle
  initial forever begin
    @(negedge clk_i);
    tick_i = ~tick_i;
  end

  // echoing receiver
  int  rise_n = 0;
  int  bad_slot = -1;
  logic sclk_prev = 0;
  initial forever begin
    @(negedge clk_i);
    if (sclk_o && !sclk_prev) begin
      fb_i = data_o ^ ((rise_n == bad_slot) ? 2'b01 : 2'b00);
      rise_n++;
    end
    sclk_prev = sclk_o;
  end

  task automatic pulse_start(logic [27:0] id);
    @(negedge clk_i);
    start_i = 1; id_i = id;
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic run(logic [27:0] id, int bad, bit poke);
    bad_slot = bad;
    rise_n = 0;
    pulse_start(id);
    if (poke) begin
      repeat (700) @(negedge clk_i);
      pulse_start(~id);   // R8: must be ignored
    end
    while (!done_o) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    check("R6 final mismatch", {1'b0, mismatch_o}, {1'b0, (bad >= 0)});
    check("R7 idle after done", {busy_o, sclk_o}, 2'b00);
  endtask

  initial begin
    repeat (5) @(negedge clk_i);
    check("R9 reset sync/sclk", {sync_o, sclk_o}, 2'b00);
    check("R9 reset data", data_o, 2'b00);
    check("R9 reset flags", {busy_o, done_o}, 2'b00);
    check("R9 reset mismatch", {1'b0, mismatch_o}, 2'b00);
    rst_ni = 1;
    repeat (3) @(negedge clk_i);
    run(28'hA5C31E7, -1, 0);
    run(28'h3FF0C96, 5, 1);
    run(28'h123ABCD, 13, 0);
    run(28'hFFFFFFF, -1, 0);   // R6: start clears flag from previous run
    run(28'h0000001, 0, 1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule